// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM of 32K bytes. The host side uses a valid/ready handshake. Each request carries an address, write data and a direction flag. Read results come back on a data output with a single-cycle valid strobe. On the memory side the controller drives a 15-bit address and three active-low strobes: chip select, write enable and output enable. The 8-bit bidirectional data bus is presented as separate out, in and driver-enable signals, so that a pad ring or a board model can join them.

The memory gives no handshake back, so every phase is timed by counting whole clock cycles. The counts come from build-time parameters: the clock period, and the memory's minimum pulse, access, data-setup and output-release times. Each count is rounded up.

Drive ownership of the data bus is sequenced. Output enable stays high for the whole of a write. After every read, a turnaround of idle cycles passes before the controller may enable its own drivers. As a result, the memory and the controller never drive the bus at the same time.

Top module: `sram_async_ctl`

## Requirements
- R1: While and after reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: Bus modes are encoded as follows:
  - read: `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1;
  - write: `mem_cs_n`=0, `mem_we_n`=0, `mem_oe_n`=1;
  - `mem_oe_n` is never 0 while `mem_we_n` is 0;
  - `mem_dq_oe` is 1 only while `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1.
- R3: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the whole memory cycle, tail included, is over. `req_valid` is ignored while `req_ready` is 0.
- R4: A read asserts its strobes in the cycle after acceptance and holds them for RD_CYC cycles. `mem_dq_in` is sampled at the edge that ends the last of those cycles. The sampled byte appears on `rd_data` with `rd_valid` high for exactly the following cycle.
- R5: A write starts with one cycle in which `mem_cs_n`=0 and `mem_we_n`=1, with address valid. Then `mem_we_n` is 0 for exactly WP_CYC cycles, with `mem_dq_oe`=1 and the write data on `mem_dq_out`. Write enable, chip select and the data drivers are all released on the same edge.
- R6: After a write, chip select stays high for WT_CYC cycles before `req_ready` returns.
- R7: After a read, chip select stays high and the drivers stay off for TURN_CYC cycles before `req_ready` returns. At least TURN_CYC cycles pass between `mem_oe_n` rising and `mem_dq_oe` rising.
- R8: Address, write data and direction are registered at acceptance. Changes on the request inputs during a memory cycle do not reach `mem_addr`, `mem_dq_out` or the operation performed.
- R9: The cycle counts use ceil(x) = ceiling of x divided by the clock period, and max(...) = the largest of the listed values:
  - RD_CYC = max(ceil(T_AA), ceil(T_ACS), ceil(T_OE));
  - WP_CYC = max(ceil(T_WP), ceil(T_AW) - 1, ceil(T_DW));
  - WT_CYC = max(1, ceil(T_WC) - 1 - WP_CYC);
  - TURN_CYC = max(TURN_MIN_CYC, ceil(T_OHZ)).

  For an 8 ns clock, these give 9, 7, 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data returned from the memory |

## Verification
A wrong phase or counter value would show up at the pins within a single transaction, in any of these ways:
- a strobe pulse that is one cycle short or long;
- a `rd_valid` that comes early or late;
- a `req_ready` that returns too soon, cutting off the write tail or the read turnaround.

The bench's memory model returns real data only in the last access cycle. A capture taken early or late therefore yields a wrong byte at once, not timing slack that goes unnoticed.

A corrupted request register would only show on a later read-back of the same address. For that reason, writes are followed quickly by reads over a small address set.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_WSET,
        PH_WPULSE,
        PH_WTAIL,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pins_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern seen on the memory pins during each phase
    function automatic pins_t pins_for(input phase_e ph);
        pins_t p;
        p = PINS_IDLE;
        case (ph)
            PH_RD:     begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            PH_WSET:   begin p.cs_n = 1'b0; end
            PH_WPULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            default:   p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 5,
    parameter int WT_CYC   = 1,
    parameter int TURN_CYC = 3,
    parameter int CNT_W    = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase_q,
    output pins_t  pins_q,
    output logic   capture
);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_d;
    logic             last;

    function automatic logic [CNT_W-1:0] load_for(input phase_e ph);
        int n;
        case (ph)
            PH_RD:     n = RD_CYC;
            PH_WPULSE: n = WP_CYC;
            PH_WTAIL:  n = WT_CYC;
            PH_TURN:   n = TURN_CYC;
            default:   n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    assign last    = (cnt_q == '0);
    assign capture = (phase_q == PH_RD) && last;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (start) phase_d = start_wr ? PH_WSET : PH_RD;
            PH_RD:     if (last) phase_d = PH_TURN;
            PH_WSET:   phase_d = PH_WPULSE;
            PH_WPULSE: if (last) phase_d = PH_WTAIL;
            PH_WTAIL:  if (last) phase_d = PH_IDLE;
            PH_TURN:   if (last) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pins_q  <= PINS_IDLE;
        end else begin
            phase_q <= phase_d;
            pins_q  <= pins_for(phase_d);
            if (phase_d != phase_q)
                cnt_q <= load_for(phase_d);
            else if (!last)
                cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output req_t              req_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (accept) begin
                req_q.addr <= in_addr;
                req_q.data <= in_data;
            end
            if (capture) rd_data <= dq_in;
            rd_valid <= capture;
        end
    end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int T_AA_NS      = 70,
    parameter int T_ACS_NS     = 70,
    parameter int T_OE_NS      = 40,
    parameter int T_OHZ_NS     = 25,
    parameter int T_WP_NS      = 50,
    parameter int T_AW_NS      = 60,
    parameter int T_DW_NS      = 30,
    parameter int T_WC_NS      = 70,
    parameter int TURN_MIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC   = imax(cdiv(T_AA_NS, CLK_NS),
                                   imax(cdiv(T_ACS_NS, CLK_NS), cdiv(T_OE_NS, CLK_NS)));
    localparam int WP_CYC   = imax(cdiv(T_WP_NS, CLK_NS),
                                   imax(cdiv(T_AW_NS, CLK_NS) - 1, cdiv(T_DW_NS, CLK_NS)));
    localparam int WT_CYC   = imax(1, cdiv(T_WC_NS, CLK_NS) - 1 - WP_CYC);
    localparam int TURN_CYC = imax(TURN_MIN_CYC, cdiv(T_OHZ_NS, CLK_NS));
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(WT_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    phase_e phase;
    pins_t  pins;
    logic   capture;
    logic   accept;
    req_t   req_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sram_seq #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .WT_CYC   (WT_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_wr (req_write),
        .phase_q  (phase),
        .pins_q   (pins),
        .capture  (capture)
    );

    sram_dpath dpath_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .in_addr  (req_addr),
        .in_data  (req_wdata),
        .capture  (capture),
        .dq_in    (mem_dq_in),
        .req_q    (req_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_addr   = req_q.addr;
    assign mem_dq_out = req_q.data;
    assign mem_cs_n   = pins.cs_n;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
    parameter int WP_CYC   = 5,
    parameter int TURN_CYC = 3,
    parameter int ADDR_W   = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    logic [7:0] we_run;
    logic [7:0] since_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run   <= '0;
            since_oe <= 8'hFF;
        end else begin
            we_run   <= mem_we_n ? 8'd0 : ((we_run == 8'hFF) ? we_run : we_run + 8'd1);
            since_oe <= !mem_oe_n ? 8'd0 : ((since_oe == 8'hFF) ? since_oe : since_oe + 8'd1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid)); // R1
    AST_NO_WE_OE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R2
    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_cs_n && !mem_we_n && mem_oe_n)); // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R3
    AST_CS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n); // R3
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R4
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run == 8'(WP_CYC))); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (since_oe >= 8'(TURN_CYC))); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .ADDR_W   (sram_ctl_pkg::ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb_top;

    localparam int CLK_NS = 8;

    function automatic int up(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts per R9
    localparam int E_RD   = mx(up(70), up(40));
    localparam int E_WP   = mx(mx(up(50), up(60) - 1), up(30));
    localparam int E_WT   = mx(1, up(70) - 1 - E_WP);
    localparam int E_TURN = mx(3, up(25));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_async_ctl #(.CLK_NS(CLK_NS)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model: real data only in the last access cycle of a read
    logic [7:0] mem_model [int];
    logic [7:0] exp_mem [int];
    int rd_age = 0;
    logic rd_mode;

    assign rd_mode = !mem_cs_n && !mem_oe_n && mem_we_n;

    always @(negedge clk)
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem_model[int'(mem_addr)] = mem_dq_out;

    always @(posedge clk) rd_age <= rd_mode ? rd_age + 1 : 0;

    always @* begin
        if (rd_mode && rd_age >= E_RD - 1)
            mem_dq_in = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    function automatic logic [7:0] expect_rd(input logic [14:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int k;
        int rv_k, ready_k, last_cs_k, first_we_k, we_cnt, data_bad, addr_bad, mode_bad;
        logic [7:0] rv_val;
        rv_k = -1; ready_k = -1; last_cs_k = -1; first_we_k = -1;
        we_cnt = 0; data_bad = 0; addr_bad = 0; mode_bad = 0; rv_val = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        k = 1;
        forever begin
            if (k == 1) begin
                check("R3 ready low after accept", int'(req_ready), 0);
                if (wr)
                    check("R5 setup cycle pins", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 'b0110);
                else
                    check("R2 read pins", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 'b0100);
            end
            if (!mem_cs_n) begin
                last_cs_k = k;
                if (mem_addr != a) addr_bad++;
            end
            if (!mem_we_n) begin
                we_cnt++;
                if (first_we_k < 0) first_we_k = k;
                if (!mem_dq_oe || mem_dq_out != d || !mem_oe_n) data_bad++;
            end
            if (wr && !mem_oe_n) mode_bad++;
            if (!wr && (!mem_we_n || mem_dq_oe)) mode_bad++;
            if (rd_valid) begin
                if (rv_k < 0) begin rv_k = k; rv_val = rd_data; end
                else mode_bad++;
            end
            if (req_ready) begin
                req_valid = 1'b0;
                ready_k = k;
                check("R7 drivers off at ready", int'(mem_dq_oe), 0);
                break;
            end
            // R3/R8: junk on the request inputs while busy
            req_write = $urandom_range(0, 1);
            req_addr  = 15'($urandom);
            req_wdata = 8'($urandom);
            if (k > 300) begin
                check("R3 watchdog op", 0, 1);
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
            k++;
        end
        check("R8 address held", addr_bad, 0);
        check("R2 mode exclusivity", mode_bad, 0);
        if (wr) begin
            check("R5 we low cycles", we_cnt, E_WP);
            check("R5 we fall cycle", first_we_k, 2);
            check("R5 data driven with we", data_bad, 0);
            check("R5 cs released with we", last_cs_k, E_WP + 1);
            check("R6 write ready latency", ready_k, E_WP + E_WT + 2);
            exp_mem[int'(a)] = d;
        end else begin
            check("R4 rd_valid cycle", rv_k, E_RD + 1);
            check("R4 rd_data", int'(rv_val), int'(expect_rd(a)));
            check("R4 strobe length", last_cs_k, E_RD);
            check("R7 read ready latency", ready_k, E_RD + E_TURN + 1);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R1 pins in reset", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 'b1110);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pins after reset", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 'b1110);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        check("R9 counts", E_RD * 1000 + E_WP * 100 + E_WT * 10 + E_TURN, 9714);

        // Directed corners
        do_op(1'b0, 15'h1234, 8'h00);   // unwritten location reads 0
        do_op(1'b1, 15'h0000, 8'hA5);
        do_op(1'b1, 15'h7FFF, 8'h5A);
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b0, 15'h0000, 8'h00);   // read-read back to back
        do_op(1'b1, 15'h0000, 8'hFF);   // write right after read: turnaround
        do_op(1'b1, 15'h0001, 8'h01);   // write-write back to back
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b0, 15'h0001, 8'h00);

        // Random traffic over a small address set
        for (int i = 0; i < 80; i++) begin
            logic [14:0] a;
            a = ($urandom_range(0, 3) == 0) ? 15'(15'h7FF0 + $urandom_range(0, 15))
                                            : 15'($urandom_range(0, 15));
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule